// File: doc/BRIEF.md
# Contact Bounce Filter

This block turns a noisy mechanical contact, such as one channel of a rotary encoder or a push button, into a clean logic level. The raw asynchronous input is first captured by a two-flop chain. Comparing the two flops flags every level change for one cycle. Each flagged change restarts a settling counter. The counter climbs to its all-ones value and then stops. In every cycle where the counter sits at that terminal value, the registered output takes the synchronized level. The output therefore moves only after the contact has held one level for a full settling interval.

The counter width `CNT_W` sets the interval at 2^CNT_W samples, and each added bit doubles it. The default of 16 bits gives about 1.3 ms at a 50 MHz clock. Widths of 17 to 19 bits suit contacts with very long bounce. The whole block runs in one clock domain. The output flop is an ordinary clocked register with a load enable; nothing is clocked by a carry signal.

Top module: `contact_debouncer`

## Requirements
- R1: While reset is high, and in the first cycle after reset falls, `clean_out` is 0. Reset also sets both synchronizer flops and the settling counter to zero.
- R2: Suppose a new level is first captured at rising edge F and then held for at least 2^CNT_W consecutive samples. `clean_out` takes that level at rising edge F + 2^CNT_W + 1, and not before.
- R3: An excursion of the input that lasts fewer than 2^CNT_W consecutive samples never reaches `clean_out`. This holds however many such excursions occur and however they are spaced.
- R4: An excursion that lasts exactly 2^CNT_W samples is passed to `clean_out`.
- R5: Once the counter reaches its terminal value (all ones), it stays there without wrapping for as long as the synchronized level does not change. Below the terminal value it advances by one per cycle when no change is flagged. `clean_out` stays constant through any steady stretch.
- R6: A change flag clears the counter to zero on the next edge. This holds even when the counter is at its terminal value, so the clear takes priority over holding.
- R7: `clean_out` changes only on an edge where the counter was at its terminal value. On such an edge it loads the second synchronizer flop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| raw_in | input | 1 | Unsynchronized level from the mechanical contact |
| clean_out | output | 1 | Filtered level, registered |

## Verification
Two functions can fall in the same edge: restarting the counter on a change flag, and loading the output while the counter sits at its terminal value. The bench provokes this overlap by flipping the input after a long steady stretch. At that point the counter is saturated and still loading the output every cycle when the change flag arrives. It does this for every excursion width from 1 to 2^CNT_W − 1 samples, in both polarities, and in pseudo-random bounce bursts. A correct design lets the restart win. The bench judges each cycle against an arithmetic model. In that model, the output at edge E takes the sample from edge E−2 only if the 2^CNT_W samples ending there are all equal. Any leak of a short excursion, or any early or late update, therefore fails the check in the exact cycle where it happens.

// File: rtl/debounce_pkg.sv
package debounce_pkg;

  // Number of consecutive identical samples needed before the output follows
  function automatic int unsigned settle_samples(input int unsigned cnt_w);
    return 32'd1 << cnt_w;
  endfunction

  // Edges from the first sample of a new level to the output update
  function automatic int unsigned update_latency(input int unsigned cnt_w);
    return settle_samples(cnt_w) + 32'd1;
  endfunction

endpackage

// File: rtl/deb_input_sync.sv
module deb_input_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic level,
  output logic change
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], raw};
  end

  // One-cycle flag whenever the two oldest stages disagree
  assign level  = chain_q[LAST];
  assign change = chain_q[LAST] ^ chain_q[LAST-1];
endmodule

// File: rtl/deb_settle_counter.sv
module deb_settle_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  output logic [CNT_W-1:0] count,
  output logic             terminal
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

  logic [CNT_W-1:0] count_q;

  assign terminal = &count_q;
  assign count    = count_q;

  // Clear beats hold, hold beats increment
  always_ff @(posedge clk) begin
    if (rst)            count_q <= '0;
    else if (restart)   count_q <= '0;
    else if (!terminal) count_q <= count_q + STEP;
  end
endmodule

// File: rtl/deb_hold_reg.sv
module deb_hold_reg (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= 1'b0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/contact_debouncer.sv
module contact_debouncer #(
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  output logic clean_out
);
  // Internal events, named for the checker
  logic             sync_level;
  logic             change_pulse;
  logic [CNT_W-1:0] settle_count;
  logic             at_terminal;

  deb_input_sync #(.STAGES(2)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .raw    (raw_in),
    .level  (sync_level),
    .change (change_pulse)
  );

  deb_settle_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .restart  (change_pulse),
    .count    (settle_count),
    .terminal (at_terminal)
  );

  deb_hold_reg u_out (
    .clk  (clk),
    .rst  (rst),
    .load (at_terminal),
    .d    (sync_level),
    .q    (clean_out)
  );
endmodule

// File: rtl/debounce_chk.sv
module debounce_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             clean_out,
  input logic             sync_level,
  input logic             change_pulse,
  input logic [CNT_W-1:0] settle_count,
  input logic             at_terminal
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

  p_reset_out_r1: assert property (@(posedge clk) $fell(rst) |-> !clean_out);

  p_restart_clears_r6: assert property (@(posedge clk) disable iff (rst)
    change_pulse |=> settle_count == '0);

  p_saturate_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (at_terminal && !change_pulse) |=> at_terminal);

  p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
    (!at_terminal && !change_pulse) |=> settle_count == $past(settle_count) + STEP);

  p_out_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    !at_terminal |=> $stable(clean_out));

  p_out_load_r7: assert property (@(posedge clk) disable iff (rst)
    at_terminal |=> clean_out == $past(sync_level));
endmodule

bind contact_debouncer debounce_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .clean_out    (clean_out),
  .sync_level   (sync_level),
  .change_pulse (change_pulse),
  .settle_count (settle_count),
  .at_terminal  (at_terminal)
);

// File: tb/tb_contact_debouncer.sv
`timescale 1ns/1ps
module tb_contact_debouncer;
  import debounce_pkg::*;

  localparam int CNT_W = 4;
  localparam int DW    = 1 << CNT_W;

  logic clk = 1'b0;
  logic rst;
  logic raw_in;
  logic clean_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string tag;

  logic [63:0] hist;
  int          edges;
  logic        exp_out;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  contact_debouncer #(.CNT_W(CNT_W)) dut (
    .clk       (clk),
    .rst       (rst),
    .raw_in    (raw_in),
    .clean_out (clean_out)
  );

  task automatic check(input logic act, input logic expv, input string req);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s edge %0d: clean_out=%b expected=%b", req, edges, act, expv);
    end
  endtask

  // Drive one sample (from a negedge), update the model at the edge, check at next negedge
  task automatic cyc(input logic v);
    bit same;
    raw_in = v;
    @(posedge clk);
    edges++;
    hist = {hist[62:0], v};
    if (edges >= int'(update_latency(CNT_W))) begin
      same = 1;
      for (int k = 3; k <= DW + 1; k++)
        if (hist[k] != hist[2]) same = 0;
      if (same) exp_out = hist[2];
    end
    @(negedge clk);
    check(clean_out, exp_out, tag);
  endtask

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    logic base;
    int   first;
    int   len;
    rst = 1'b1; raw_in = 1'b1; hist = '0; edges = 0; exp_out = 1'b0;
    repeat (3) @(negedge clk);
    tag = "R1";
    check(clean_out, 1'b0, "R1");
    rst = 1'b0; raw_in = 1'b0;
    for (int i = 0; i < 24; i++) cyc(1'b0);

    // R2: exact latency of a clean step, counted arithmetically
    tag = "R2";
    first = edges + 1;
    for (int i = 0; i < DW + 8; i++) begin
      cyc(1'b1);
      checks++;
      if ((edges - first < DW + 1) && clean_out !== 1'b0) begin
        errors++;
        $display("FAIL R2 early update at edge %0d: clean_out=%b expected=0", edges, clean_out);
      end
      if ((edges - first >= DW + 1) && clean_out !== 1'b1) begin
        errors++;
        $display("FAIL R2 late update at edge %0d: clean_out=%b expected=1", edges, clean_out);
      end
    end

    // R3 / R6: every short width, both polarities, on a saturated counter
    for (int pol = 0; pol < 2; pol++) begin
      tag = "R6";
      for (int i = 0; i < DW + 4; i++) cyc(pol[0]);
      base = pol[0];
      tag = "R3";
      for (int w = 1; w < DW; w++) begin
        for (int i = 0; i < w; i++) cyc(~base);
        for (int i = 0; i < DW + 3; i++) cyc(base);
        checks++;
        if (clean_out !== base) begin
          errors++;
          $display("FAIL R3 width %0d leaked: clean_out=%b expected=%b", w, clean_out, base);
        end
      end
      // R4: boundary width passes
      tag = "R4";
      for (int i = 0; i < DW; i++) cyc(~base);
      cyc(~base);
      cyc(~base);
      checks++;
      if (clean_out !== ~base) begin
        errors++;
        $display("FAIL R4 full-width excursion: clean_out=%b expected=%b", clean_out, ~base);
      end
      for (int i = 0; i < DW + 4; i++) cyc(base);
    end

    // R3: pseudo-random bounce bursts, each run shorter than the interval
    tag = "R3";
    for (int b = 0; b < 12; b++) begin
      base = clean_out;
      for (int s = 0; s < 10; s++) begin
        lfsr = lfsr_next(lfsr);
        len = 1 + int'(lfsr[3:0]) % (DW - 1);
        for (int i = 0; i < len; i++) cyc(s[0] ? base : ~base);
      end
      for (int i = 0; i < DW + 4; i++) cyc(b[0]);
    end

    // R5: long steady stretch, output must not move
    tag = "R5";
    base = clean_out;
    for (int i = 0; i < 5 * DW; i++) begin
      cyc(base);
      checks++;
      if (clean_out !== base) begin
        errors++;
        $display("FAIL R5 output moved while steady: clean_out=%b expected=%b", clean_out, base);
      end
    end

    // R7: output only moves at the modelled terminal edge (model check each cycle)
    tag = "R7";
    for (int i = 0; i < DW + 4; i++) cyc(~base);

    finish_run();
  end
endmodule